// File: doc/BRIEF.md
# Bus Cycle Strobe Sequencer

This block runs one bus cycle on an 8-bit data bus at a time. An accepted cycle steps through a lead clock, then T1, T2, T3, any number of wait states (Tw) and T4. For that cycle it produces the command and steering strobes: an address-latch pulse, a write strobe, an interrupt-acknowledge read strobe, a transceiver enable, a transfer-direction line, a memory/I/O select line and a low status bit. The three status lines together carry a fixed 3-bit code for the cycle type.

The strobes change on both clock edges. A register on the rising edge tracks the T-state. A copy of it is taken on the falling edge. Each strobe is decoded from the pair, so every strobe edge falls on a half-clock boundary of a named T-state.

A hold handler can take the bus away through a float request. While the bus is floated, the steering lines and the write and enable strobes read as logic one and the drive-enable output is low.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is high and after it is released with no request, outputs show the idle state: `{io_space,xmit_dir,stat_lo}` = 011, `addr_strobe`=0, `wstb_n`=`ackstb_n`=`xcvr_en_n`=1 and `bus_driven`=1.
- R2: `req_accept` is high in the same cycle when `req_valid` is high, `float_req` is low and the sequencer is idle or in the final T4. An accepted cycle runs one lead clock, then T1, T2, T3, then T4, with no idle clock between back-to-back cycles.
- R3: `addr_strobe` is high only in the second (clock-low) half of T1.
- R4: For kinds 010 and 110 (memory and I/O write), `wstb_n` is low from the start of T2 to the end of T3 or of the last Tw.
- R5: For kind 100 (interrupt acknowledge), `ackstb_n` is low over the same span as R4.
- R6: `xcvr_en_n` is low from mid-T2 to mid-T4 for kinds 000, 001, 101 and 100, and from the start of T2 to mid-T4 for kinds 010 and 110. It stays high for kind 111 (halt).
- R7: `{io_space,xmit_dir,stat_lo}` equals the accepted kind from the lead clock through the final T4. The code table is 100 acknowledge, 101 I/O read, 110 I/O write, 111 halt, 000 code fetch, 001 memory read, 010 memory write and 011 passive. The lines return to 011 when idle.
- R8: `rdy` is sampled at the rising edge that ends T3 and at the edge that ends each Tw. If it is low, one more Tw follows. If it is high, T4 follows.
- R9: `float_req`, sampled when idle or at the end of the final T4, has priority over a request. The bus then floats from the next clock: `bus_driven`=0, `io_space`, `xmit_dir`, `stat_lo`, `wstb_n` and `xcvr_en_n` read 1, `addr_strobe`=0, `ackstb_n`=1, and no request is accepted. One clock after `float_req` falls, the sequencer is idle again.
- R10: A request of kind 011 (passive) is never accepted and leaves the outputs in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A cycle request is present |
| req_kind | input | 3 | Requested cycle code (R7 table) |
| rdy | input | 1 | Ready; low inserts wait states |
| float_req | input | 1 | Hold handler asks for the bus to float |
| req_accept | output | 1 | Request taken at the coming rising edge |
| addr_strobe | output | 1 | Address latch pulse, high active |
| wstb_n | output | 1 | Write strobe, low active |
| ackstb_n | output | 1 | Interrupt-acknowledge read strobe, low active |
| xcvr_en_n | output | 1 | Data transceiver enable, low active |
| xmit_dir | output | 1 | Transfer direction, 1 = transmit |
| io_space | output | 1 | 1 = I/O space, 0 = memory |
| stat_lo | output | 1 | Low status bit of the cycle code |
| bus_driven | output | 1 | 0 while the bus is floated |

## Verification
Cycles are run one at a time and back to back. This separates the idle return path from the direct T4-to-lead path. Read and acknowledge cycles are set against write cycles to tell apart the two start points of the transceiver enable and to keep each strobe with its own kind. Halt cycles show the case where only the address pulse fires. Zero, one and two wait states test the `rdy` sampling point. Float is requested both while idle and while a request is pending in the final T4, which tests its priority and the forced-one values. A passive-code request tests that it is refused.

// File: rtl/bus_seq_pkg.sv
`timescale 1ns/1ps
package bus_seq_pkg;

    localparam int KIND_W = 3;
    typedef logic [KIND_W-1:0] kind_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_LEAD, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4, PH_HOLD
    } tphase_e;

    localparam kind_t K_ACK   = 3'b100;
    localparam kind_t K_IORD  = 3'b101;
    localparam kind_t K_IOWR  = 3'b110;
    localparam kind_t K_FETCH = 3'b000;
    localparam kind_t K_MEMRD = 3'b001;
    localparam kind_t K_MEMWR = 3'b010;
    localparam kind_t K_IDLE  = 3'b011;

    typedef struct packed {
        logic  strobe_addr;
        logic  wr_n;
        logic  ack_n;
        logic  en_n;
        kind_t stat;
        logic  driven;
    } bus_out_t;

    function automatic logic kind_is_write(kind_t k);
        return (k == K_IOWR) || (k == K_MEMWR);
    endfunction

    function automatic logic kind_is_ack(kind_t k);
        return k == K_ACK;
    endfunction

    function automatic logic kind_is_read(kind_t k);
        return (k == K_FETCH) || (k == K_MEMRD) || (k == K_IORD);
    endfunction

    function automatic logic in_data_span(tphase_e p);
        return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
    endfunction

endpackage

// File: rtl/bus_tstate_fsm.sv
`timescale 1ns/1ps
module bus_tstate_fsm
    import bus_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  kind_t   req_kind,
    input  logic    rdy,
    input  logic    float_req,
    output tphase_e phase,
    output kind_t   kind_q,
    output logic    req_accept
);

    tphase_e phase_nx;
    logic    can_take;

    always_comb begin
        can_take   = ((phase == PH_IDLE) || (phase == PH_T4)) && !float_req;
        req_accept = can_take && req_valid && (req_kind != K_IDLE);
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE, PH_T4: begin
                if (float_req)       phase_nx = PH_HOLD;
                else if (req_accept) phase_nx = PH_LEAD;
                else                 phase_nx = PH_IDLE;
            end
            PH_LEAD: phase_nx = PH_T1;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3, PH_TW: phase_nx = rdy ? PH_T4 : PH_TW;
            PH_HOLD: phase_nx = float_req ? PH_HOLD : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            kind_q <= K_IDLE;
        end else begin
            phase <= phase_nx;
            if (req_accept)
                kind_q <= req_kind;
            else if ((phase_nx == PH_IDLE) || (phase_nx == PH_HOLD))
                kind_q <= K_IDLE;
        end
    end

endmodule

// File: rtl/bus_phase_capture.sv
`timescale 1ns/1ps
module bus_phase_capture
    import bus_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tphase_e phase_p,
    output tphase_e phase_n
);

    always_ff @(negedge clk) begin
        if (rst) phase_n <= PH_IDLE;
        else     phase_n <= phase_p;
    end

endmodule

// File: rtl/bus_strobe_gen.sv
`timescale 1ns/1ps
module bus_strobe_gen
    import bus_seq_pkg::*;
(
    input  tphase_e  phase_p,
    input  tphase_e  phase_n,
    input  kind_t    kind,
    output bus_out_t outs
);

    logic span_p, span_n, floated, wr_k, rd_k, ack_k, en_act;

    always_comb begin
        span_p  = in_data_span(phase_p);
        span_n  = in_data_span(phase_n);
        floated = (phase_p == PH_HOLD);
        wr_k    = kind_is_write(kind);
        ack_k   = kind_is_ack(kind);
        rd_k    = kind_is_read(kind);
        en_act  = ((rd_k || ack_k) && span_n) || (wr_k && (span_p || span_n));

        outs.strobe_addr = (phase_p == PH_T1) && (phase_n == PH_T1);
        outs.wr_n        = floated || !(wr_k && span_p);
        outs.ack_n       = !(ack_k && span_p);
        outs.en_n        = floated || !en_act;
        outs.stat        = floated ? '1 : kind;
        outs.driven      = !floated;
    end

endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       rdy,
    input  logic       float_req,
    output logic       req_accept,
    output logic       addr_strobe,
    output logic       wstb_n,
    output logic       ackstb_n,
    output logic       xcvr_en_n,
    output logic       xmit_dir,
    output logic       io_space,
    output logic       stat_lo,
    output logic       bus_driven
);

    tphase_e  phase_p;
    tphase_e  phase_n;
    kind_t    kind_q;
    bus_out_t outs;

    bus_tstate_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .rdy        (rdy),
        .float_req  (float_req),
        .phase      (phase_p),
        .kind_q     (kind_q),
        .req_accept (req_accept)
    );

    bus_phase_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .phase_p (phase_p),
        .phase_n (phase_n)
    );

    bus_strobe_gen u_gen (
        .phase_p (phase_p),
        .phase_n (phase_n),
        .kind    (kind_q),
        .outs    (outs)
    );

    assign addr_strobe = outs.strobe_addr;
    assign wstb_n      = outs.wr_n;
    assign ackstb_n    = outs.ack_n;
    assign xcvr_en_n   = outs.en_n;
    assign io_space    = outs.stat[2];
    assign xmit_dir    = outs.stat[1];
    assign stat_lo     = outs.stat[0];
    assign bus_driven  = outs.driven;

endmodule

// File: rtl/bus_cycle_seq_chk.sv
`timescale 1ns/1ps
module bus_cycle_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_kind,
    input logic       req_accept,
    input logic       addr_strobe,
    input logic       wstb_n,
    input logic       ackstb_n,
    input logic       xcvr_en_n,
    input logic       xmit_dir,
    input logic       io_space,
    input logic       stat_lo,
    input logic       bus_driven
);

    AST_STROBE_LATE_HALF: assert property (@(negedge clk) disable iff (rst) !addr_strobe); // R3
    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) addr_strobe |=> !addr_strobe); // R3
    AST_STROBE_ALONE: assert property (@(posedge clk) disable iff (rst) addr_strobe |-> (wstb_n && ackstb_n && xcvr_en_n)); // R3
    AST_WRITE_CODE: assert property (@(posedge clk) disable iff (rst) !wstb_n |-> (xmit_dir && !stat_lo && !xcvr_en_n)); // R4
    AST_ACK_CODE: assert property (@(posedge clk) disable iff (rst) !ackstb_n |-> ({io_space, xmit_dir, stat_lo} == 3'b100)); // R5
    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst) !(!wstb_n && !ackstb_n)); // R4
    AST_FLOAT_FORCED: assert property (@(posedge clk) disable iff (rst) !bus_driven |-> (io_space && xmit_dir && stat_lo && wstb_n && xcvr_en_n && ackstb_n)); // R9
    AST_FLOAT_NO_TAKE: assert property (@(posedge clk) disable iff (rst) !bus_driven |-> !req_accept); // R9
    AST_PASSIVE_REFUSED: assert property (@(posedge clk) disable iff (rst) req_accept |-> (req_valid && req_kind != 3'b011)); // R10

endmodule

bind bus_cycle_seq bus_cycle_seq_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_accept  (req_accept),
    .addr_strobe (addr_strobe),
    .wstb_n      (wstb_n),
    .ackstb_n    (ackstb_n),
    .xcvr_en_n   (xcvr_en_n),
    .xmit_dir    (xmit_dir),
    .io_space    (io_space),
    .stat_lo     (stat_lo),
    .bus_driven  (bus_driven)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

    typedef enum {BIDLE, BLEAD, B1, B2, B3, BW, B4, BHOLD} bph_e;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'b011;
    logic       rdy = 1'b1;
    logic       float_req = 1'b0;
    logic       req_accept, addr_strobe, wstb_n, ackstb_n, xcvr_en_n;
    logic       xmit_dir, io_space, stat_lo, bus_driven;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    bus_cycle_seq i_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .rdy(rdy), .float_req(float_req), .req_accept(req_accept),
        .addr_strobe(addr_strobe), .wstb_n(wstb_n), .ackstb_n(ackstb_n),
        .xcvr_en_n(xcvr_en_n), .xmit_dir(xmit_dir), .io_space(io_space),
        .stat_lo(stat_lo), .bus_driven(bus_driven)
    );

    function automatic logic [7:0] actual_vec();
        return {addr_strobe, wstb_n, ackstb_n, xcvr_en_n, io_space, xmit_dir, stat_lo, bus_driven};
    endfunction

    // Expected outputs for one half-clock, from the requirements
    function automatic logic [7:0] expect_for(bph_e ph, bit second, logic [2:0] kind);
        bit wr   = (kind == 3'b010) || (kind == 3'b110);
        bit ack  = (kind == 3'b100);
        bit rd   = (kind == 3'b000) || (kind == 3'b001) || (kind == 3'b101);
        bit body = (ph == B2) || (ph == B3) || (ph == BW);
        bit hold = (ph == BHOLD);
        bit ena;
        logic [2:0] st;
        if (rd || ack) ena = (ph == B2 && second) || ph == B3 || ph == BW || (ph == B4 && !second);
        else if (wr)   ena = body || (ph == B4 && !second);
        else           ena = 1'b0;
        st = hold ? 3'b111 : (ph == BIDLE) ? 3'b011 : kind;
        return {(ph == B1 && second), hold | !(wr && body), !(ack && body),
                hold | !ena, st, !hold};
    endfunction

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Driver primitive: after the next rising edge, queue both halves of that clock
    task automatic half_pair(bph_e ph, logic [2:0] kind, string tag);
        @(posedge clk);
        #1;
        exp_q.push_back(expect_for(ph, 1'b0, kind));
        tag_q.push_back(tag);
        exp_q.push_back(expect_for(ph, 1'b1, kind));
        tag_q.push_back(tag);
    endtask

    task automatic run_cycle(logic [2:0] kind, int nwait, string tag);
        req_valid = 1'b1;
        req_kind  = kind;
        #1;
        check_bit("R2", "req_accept", req_accept, 1'b1);
        half_pair(BLEAD, kind, tag);
        req_valid = 1'b0;
        half_pair(B1, kind, tag);
        half_pair(B2, kind, tag);
        half_pair(B3, kind, tag);
        rdy = (nwait == 0);
        for (int i = 0; i < nwait; i++) begin
            half_pair(BW, kind, tag);
            rdy = (i == nwait - 1);
        end
        half_pair(B4, kind, tag);
        rdy = 1'b1;
    endtask

    task automatic compare_one();
        logic [7:0] e = exp_q.pop_front();
        string      t = tag_q.pop_front();
        logic [7:0] a = actual_vec();
        n_checks++;
        if (a !== e) begin
            n_fails++;
            if (a[7] !== e[7]) $display("FAIL R3 [%s] addr_strobe actual=%b expected=%b", t, a[7], e[7]);
            else if (a[6] !== e[6]) $display("FAIL R4 [%s] wstb_n actual=%b expected=%b", t, a[6], e[6]);
            else if (a[5] !== e[5]) $display("FAIL R5 [%s] ackstb_n actual=%b expected=%b", t, a[5], e[5]);
            else if (a[4] !== e[4]) $display("FAIL R6 [%s] xcvr_en_n actual=%b expected=%b", t, a[4], e[4]);
            else if (a[3:1] !== e[3:1]) $display("FAIL R7 [%s] status actual=%b expected=%b", t, a[3:1], e[3:1]);
            else $display("FAIL R9 [%s] bus_driven actual=%b expected=%b", t, a[0], e[0]);
        end
    endtask

    // Monitor: one comparison per half-clock while expectations are queued
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) compare_one();
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) compare_one();
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state in both halves
        repeat (3) @(posedge clk);
        #5;
        check_bit("R1", "vector high half", (actual_vec() == 8'b0111_0111), 1'b1);
        @(negedge clk);
        #5;
        check_bit("R1", "vector low half", (actual_vec() == 8'b0111_0111), 1'b1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        half_pair(BIDLE, 3'b011, "R1 idle");

        run_cycle(3'b001, 0, "R2 mem read");
        half_pair(BIDLE, 3'b011, "R7 idle return");
        run_cycle(3'b010, 0, "R4 mem write");
        half_pair(BIDLE, 3'b011, "R7 idle return");
        run_cycle(3'b100, 0, "R5 ack");
        half_pair(BIDLE, 3'b011, "R7 idle return");
        run_cycle(3'b101, 2, "R8 io read 2 waits");
        half_pair(BIDLE, 3'b011, "R7 idle return");
        run_cycle(3'b110, 1, "R8 io write 1 wait");
        // R2: back to back, fetch then write then ack with a wait
        run_cycle(3'b000, 0, "R2 fetch");
        run_cycle(3'b010, 0, "R2 chained write");
        run_cycle(3'b100, 1, "R8 chained ack wait");
        half_pair(BIDLE, 3'b011, "R7 idle return");
        run_cycle(3'b111, 0, "R6 halt");
        half_pair(BIDLE, 3'b011, "R7 idle return");

        // R10: passive request refused
        req_valid = 1'b1;
        req_kind  = 3'b011;
        #1;
        check_bit("R10", "req_accept", req_accept, 1'b0);
        half_pair(BIDLE, 3'b011, "R10 passive ignored");
        half_pair(BIDLE, 3'b011, "R10 passive ignored");
        req_valid = 1'b0;

        // R9: float while idle, request refused during hold
        float_req = 1'b1;
        half_pair(BHOLD, 3'b011, "R9 hold idle");
        req_valid = 1'b1;
        req_kind  = 3'b001;
        #1;
        check_bit("R9", "req_accept in hold", req_accept, 1'b0);
        half_pair(BHOLD, 3'b011, "R9 hold");
        req_valid = 1'b0;
        float_req = 1'b0;
        half_pair(BIDLE, 3'b011, "R9 release");

        // R9: float beats a pending request at the final T4
        run_cycle(3'b001, 0, "R9 before hold");
        float_req = 1'b1;
        req_valid = 1'b1;
        req_kind  = 3'b010;
        #1;
        check_bit("R9", "req_accept at T4 with float", req_accept, 1'b0);
        half_pair(BHOLD, 3'b011, "R9 hold after T4");
        req_valid = 1'b0;
        float_req = 1'b0;
        half_pair(BIDLE, 3'b011, "R9 release");
        run_cycle(3'b110, 0, "R9 after release");
        half_pair(BIDLE, 3'b011, "R7 idle return");

        repeat (2) @(posedge clk);
        #20;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule